// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programming state of a small group of DMA channels. Each channel has a 16-bit base address and a 16-bit base count, plus a working address and a working count that a transfer engine advances. A host reaches all of these through one 8-bit data port and a 4-bit register index. A single shared byte pointer selects whether an access touches the low or the high byte, and every valid access flips that pointer. A host therefore writes a 16-bit value as two consecutive byte writes, low byte first.

Writing the high byte of either base register starts the channel afresh. The working address is loaded from the base address and the working count is cleared. Reads do not return the stored registers directly. A count read reports how much of the block remains, which is the base count minus the progress. An address read reports the address reached, moving up or down according to the channel's decrement bit. A transfer engine reports its progress through a one-cycle update port. A parameter selects the word-wide variant, which keeps its working values in units of bytes and reports them back in units of words.

Top module: `dma_chan_regfile`

## Requirements
- R1: The register index is decoded as follows. Bits [3:1] select the channel, and bit 0 selects the address register (0) or the count register (1). Indices 0 to 2*NUM_CH-1 are valid.
- R2: Every valid read or write toggles the shared byte pointer. Pointer 0 accesses bits [7:0] and pointer 1 accesses bits [15:8].
- R3: A write with pointer 0 changes only bits [7:0] of the selected base register. A write with pointer 1 changes only bits [15:8].
- R4: A write with pointer 1 loads the channel's working address from its base address, shifted left by SHIFT, and clears the working count. A write with pointer 0 leaves both working registers unchanged.
- R5: A count read returns ((base count << SHIFT) - working count) modulo 2^(16+SHIFT), shifted right by SHIFT, as the byte chosen by the pointer.
- R6: An address read returns the working address plus the working count when the channel's dir_down bit is 0, and minus the working count when it is 1. The result is taken modulo 2^(16+SHIFT), shifted right by SHIFT, and returned as the byte chosen by the pointer.
- R7: With SHIFT=1, base values are doubled when loaded into the working address, and every readback is halved before the byte is selected.
- R8: ptr_clear forces the pointer to 0 on the next edge. This takes priority over the toggle from an access in the same cycle, and that access still uses the old pointer value.
- R9: An access with an invalid index writes nothing and leaves the pointer unchanged. A read at an invalid index returns 0.
- R10: An update with upd_valid loads upd_count into the selected channel's working count. If a pointer-1 write to the same channel happens in the same cycle, the clear from that write wins.
- R11: A synchronous active-high reset clears all registers and the pointer. A read result appears on rd_data, with rd_valid high, exactly one cycle after the read access, and rd_valid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 4 | Register index (channel and address/count select) |
| acc_wdata | input | 8 | Write byte |
| ptr_clear | input | 1 | Force the byte pointer to 0 |
| dir_down | input | NUM_CH | Per-channel decrement bit (bit 5 of the channel's mode byte) |
| upd_valid | input | 1 | Working-count update strobe from the transfer engine |
| upd_chan | input | $clog2(NUM_CH) | Channel for the update |
| upd_count | input | 16+SHIFT | New working count |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |

## Verification
Two instances run side by side from the same stimulus, one byte-wide and one word-wide. Every read is therefore compared in both scalings, which tells a missing or misplaced shift apart from an arithmetic fault. Directed sequences cover several cases: paired writes against a lone low-byte write, which separates the byte-lane update from the reload; progress in both directions; and progress larger than the base count, which exposes wrong wraparound. Pointer handling is covered by accesses to invalid indices, by a clear arriving in the same cycle as an access, and by a high-byte write that collides with an update. A long pseudo-random run of mixed accesses, updates and direction changes follows.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  localparam int BASE_W = 16;
  localparam int IDX_W  = 4;
  typedef enum logic {REG_ADDR = 1'b0, REG_CNT = 1'b1} reg_sel_e;
endpackage

// File: rtl/dmarf_byte_ptr.sv
module dmarf_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (rst)        ptr <= 1'b0;
    else if (clear) ptr <= 1'b0;
    else if (step)  ptr <= ~ptr;
  end

  a_r2_ptr_toggles: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (ptr != $past(ptr)));
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clear |=> !ptr);
  a_r9_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(ptr));
endmodule

// File: rtl/dmarf_channel.sv
module dmarf_channel
  import dmarf_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int CUR_W = BASE_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  reg_sel_e         wr_sel,
  input  logic [7:0]       wr_byte,
  input  logic             upd_en,
  input  logic [CUR_W-1:0] upd_cnt,
  output logic [BASE_W-1:0] base_cnt,
  output logic [CUR_W-1:0] cur_addr,
  output logic [CUR_W-1:0] cur_cnt
);
  logic [BASE_W-1:0] base_addr;
  logic [BASE_W-1:0] nxt_addr, nxt_cnt;

  // byte-lane merge of the incoming write
  always_comb begin
    nxt_addr = base_addr;
    nxt_cnt  = base_cnt;
    if (wr_en && wr_sel == REG_ADDR) begin
      if (wr_hi) nxt_addr = {wr_byte, base_addr[7:0]};
      else       nxt_addr = {base_addr[15:8], wr_byte};
    end
    if (wr_en && wr_sel == REG_CNT) begin
      if (wr_hi) nxt_cnt = {wr_byte, base_cnt[7:0]};
      else       nxt_cnt = {base_cnt[15:8], wr_byte};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else begin
      base_addr <= nxt_addr;
      base_cnt  <= nxt_cnt;
      if (wr_en && wr_hi) begin
        cur_addr <= CUR_W'(nxt_addr) << SHIFT;
        cur_cnt  <= '0;
      end else if (upd_en) begin
        cur_cnt <= upd_cnt;
      end
    end
  end

  a_r4_reload_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hi) |=> (cur_cnt == '0));
  a_r4_low_keeps_work: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi && !upd_en) |=> ($stable(cur_addr) && $stable(cur_cnt)));
  a_r3_low_lane_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi && wr_sel == REG_CNT) |=> (base_cnt[15:8] == $past(base_cnt[15:8])));
  a_r10_upd_load: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !(wr_en && wr_hi)) |=> (cur_cnt == $past(upd_cnt)));
endmodule

// File: rtl/dmarf_readback.sv
module dmarf_readback
  import dmarf_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int CUR_W = BASE_W + SHIFT
) (
  input  logic [BASE_W-1:0] base_cnt,
  input  logic [CUR_W-1:0]  cur_addr,
  input  logic [CUR_W-1:0]  cur_cnt,
  input  logic              down,
  input  reg_sel_e          sel,
  input  logic              hi,
  output logic [7:0]        rb_byte
);
  logic [CUR_W-1:0]  remain, reached, picked;
  logic [BASE_W-1:0] scaled;

  always_comb begin
    remain  = (CUR_W'(base_cnt) << SHIFT) - cur_cnt;
    reached = down ? (cur_addr - cur_cnt) : (cur_addr + cur_cnt);
    picked  = (sel == REG_CNT) ? remain : reached;
    scaled  = BASE_W'(picked >> SHIFT);
    rb_byte = hi ? scaled[15:8] : scaled[7:0];
  end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dmarf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  localparam int SEL_W = $clog2(NUM_CH),
  localparam int CUR_W = BASE_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [7:0]        acc_wdata,
  input  logic              ptr_clear,
  input  logic [NUM_CH-1:0] dir_down,
  input  logic              upd_valid,
  input  logic [SEL_W-1:0]  upd_chan,
  input  logic [CUR_W-1:0]  upd_count,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic             hit;
  logic [SEL_W-1:0] ch_idx;
  reg_sel_e         sel;
  logic             ptr;
  logic [7:0]       rb_byte;

  logic [BASE_W-1:0] base_cnt_q [NUM_CH];
  logic [CUR_W-1:0]  cur_addr_q [NUM_CH];
  logic [CUR_W-1:0]  cur_cnt_q  [NUM_CH];

  assign hit    = int'(acc_idx[IDX_W-1:1]) < NUM_CH;
  assign ch_idx = acc_idx[SEL_W:1];
  assign sel    = reg_sel_e'(acc_idx[0]);

  dmarf_byte_ptr u_ptr (
    .clk   (clk),
    .rst   (rst),
    .clear (ptr_clear),
    .step  (acc_valid && hit),
    .ptr   (ptr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmarf_channel #(.SHIFT(SHIFT)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (acc_valid && acc_write && hit && ch_idx == SEL_W'(g)),
      .wr_hi    (ptr),
      .wr_sel   (sel),
      .wr_byte  (acc_wdata),
      .upd_en   (upd_valid && upd_chan == SEL_W'(g)),
      .upd_cnt  (upd_count),
      .base_cnt (base_cnt_q[g]),
      .cur_addr (cur_addr_q[g]),
      .cur_cnt  (cur_cnt_q[g])
    );
  end

  dmarf_readback #(.SHIFT(SHIFT)) u_rb (
    .base_cnt (base_cnt_q[ch_idx]),
    .cur_addr (cur_addr_q[ch_idx]),
    .cur_cnt  (cur_cnt_q[ch_idx]),
    .down     (dir_down[ch_idx]),
    .sel      (sel),
    .hi       (ptr),
    .rb_byte  (rb_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= hit ? rb_byte : 8'h00;
    end
  end

  a_r11_rd_follows: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);
  a_r11_rd_quiet: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_write) |=> !rd_valid);
  a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && !hit) |=> (rd_data == 8'h00));
endmodule

// File: tb/dma_chan_regfile_bench.sv
module dma_chan_regfile_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0, acc_write = 1'b0, ptr_clear = 1'b0, upd_valid = 1'b0;
  logic [3:0]  acc_idx = '0;
  logic [7:0]  acc_wdata = '0;
  logic [3:0]  dir_down = '0;
  logic [1:0]  upd_chan = '0;
  logic [16:0] upd_count = '0;
  logic rv0, rv1;
  logic [7:0] rd0, rd1;

  always #10 clk = ~clk;

  dma_chan_regfile #(.NUM_CH(4), .SHIFT(0)) u_dma_chan_regfile (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .ptr_clear(ptr_clear),
    .dir_down(dir_down), .upd_valid(upd_valid), .upd_chan(upd_chan),
    .upd_count(upd_count[15:0]), .rd_valid(rv0), .rd_data(rd0));

  dma_chan_regfile #(.NUM_CH(4), .SHIFT(1)) u_dma_chan_regfile_w (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .ptr_clear(ptr_clear),
    .dir_down(dir_down), .upd_valid(upd_valid), .upd_chan(upd_chan),
    .upd_count(upd_count), .rd_valid(rv1), .rd_data(rd1));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  int b_addr [4], b_cnt [4], snap [4], ccnt [4];
  bit ptr_m = 0;

  byte unsigned q_exp [2][$];
  string        q_tag [2][$];

  function automatic int expv(int s, int ch, bit isc, bit p);
    int m = (1 << (16 + s)) - 1;
    int v;
    if (isc) v = ((b_cnt[ch] << s) - ccnt[ch]) & m;
    else if (dir_down[ch]) v = ((snap[ch] << s) - ccnt[ch]) & m;
    else v = ((snap[ch] << s) + ccnt[ch]) & m;
    return (v >> (s + 8 * int'(p))) & 255;
  endfunction

  task automatic check(bit ok, string req, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // monitor: pops expected bytes as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rv0) begin
        if (q_exp[0].size() == 0) check(0, "R11 unexpected rd_valid byte", rd0, 0);
        else begin
          automatic int e = q_exp[0].pop_front();
          automatic string t = q_tag[0].pop_front();
          check(rd0 == e, t, rd0, e);
        end
      end
      if (rv1) begin
        if (q_exp[1].size() == 0) check(0, "R11 unexpected rd_valid word", rd1, 0);
        else begin
          automatic int e = q_exp[1].pop_front();
          automatic string t = q_tag[1].pop_front();
          check(rd1 == e, {t, " R7 word"}, rd1, e);
        end
      end
    end
  end

  // one access, optional same-cycle clear and update; model applied in order
  task automatic access(bit wr, logic [3:0] idx, logic [7:0] d, string req,
                        bit clr = 0, bit upd = 0, int uch = 0, int uval = 0);
    bit valid = idx < 8;
    int ch = int'(idx[2:1]);
    bit isc = idx[0];
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_idx = idx; acc_wdata = d;
    ptr_clear = clr; upd_valid = upd; upd_chan = 2'(uch); upd_count = 17'(uval);
    if (!wr) begin
      for (int s = 0; s < 2; s++) begin
        q_exp[s].push_back(valid ? 8'(expv(s, ch, isc, ptr_m)) : 8'h00);
        q_tag[s].push_back(req);
      end
    end
    if (upd) ccnt[uch] = uval;
    if (valid) begin
      if (wr) begin
        if (!ptr_m) begin
          if (isc) b_cnt[ch] = (b_cnt[ch] & 'hFF00) | d;
          else     b_addr[ch] = (b_addr[ch] & 'hFF00) | d;
        end else begin
          if (isc) b_cnt[ch] = (b_cnt[ch] & 'h00FF) | (int'(d) << 8);
          else     b_addr[ch] = (b_addr[ch] & 'h00FF) | (int'(d) << 8);
          snap[ch] = b_addr[ch];
          ccnt[ch] = 0;
        end
      end
      ptr_m = clr ? 1'b0 : ~ptr_m;
    end else if (clr) ptr_m = 0;
    @(negedge clk);
    acc_valid = 0; ptr_clear = 0; upd_valid = 0;
  endtask

  task automatic update(int uch, int uval);
    @(negedge clk);
    upd_valid = 1; upd_chan = 2'(uch); upd_count = 17'(uval);
    ccnt[uch] = uval;
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic clear_ptr();
    @(negedge clk); ptr_clear = 1; ptr_m = 0;
    @(negedge clk); ptr_clear = 0;
  endtask

  task automatic wr16(int ch, bit isc, int v, string req);
    access(1, 4'(ch * 2 + int'(isc)), 8'(v), req);
    access(1, 4'(ch * 2 + int'(isc)), 8'(v >> 8), req);
  endtask

  task automatic rd16(int ch, bit isc, string req);
    access(0, 4'(ch * 2 + int'(isc)), 8'h00, req);
    access(0, 4'(ch * 2 + int'(isc)), 8'h00, req);
  endtask

  initial begin
    #(20 * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin b_addr[i] = 0; b_cnt[i] = 0; snap[i] = 0; ccnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(rv0 == 0 && rv1 == 0, "R11 rd_valid low after reset", rv0, 0);
    // R11 reset state readback
    rd16(0, 1, "R11 reset count");
    rd16(3, 0, "R11 reset address");
    // R3 R4 program channel 0
    wr16(0, 0, 'h1234, "R3");
    wr16(0, 1, 'h0010, "R3");
    rd16(0, 0, "R4 address reload");
    rd16(0, 1, "R5 count readback");
    // R5 R6 progress upward then downward
    update(0, 5);
    rd16(0, 0, "R6 address up");
    rd16(0, 1, "R5 remaining");
    @(negedge clk); dir_down[0] = 1;
    rd16(0, 0, "R6 address down");
    // R4 a lone low-byte write does not reload
    wr16(2, 0, 'hBBAA, "R1 channel 2");
    update(2, 3);
    access(1, 4'd4, 8'hCC, "R4 low only");
    access(0, 4'd4, 8'h00, "R4 no reload high");
    clear_ptr();
    rd16(2, 0, "R4 no reload");
    // R9 invalid index: no write, no toggle, reads 0
    access(1, 4'd9, 8'h77, "R9 write");
    access(0, 4'd13, 8'h00, "R9 read zero");
    rd16(2, 0, "R9 pointer unchanged");
    // R8 clear in same cycle as an access
    access(0, 4'd1, 8'h00, "R8 access with clear", 1);
    access(0, 4'd1, 8'h00, "R8 low after clear");
    clear_ptr();
    // R10 update collides with a reloading write on the same channel
    wr16(1, 0, 'h4000, "R1 channel 1");
    update(1, 9);
    access(1, 4'd3, 8'h20, "R10");
    access(1, 4'd3, 8'h00, "R10 collide", 0, 1, 1, 77);
    rd16(1, 0, "R10 reload wins");
    update(1, 12);
    rd16(1, 1, "R10 update loads");
    // R5 wrap: progress beyond base count
    wr16(3, 1, 'h0004, "R3 channel 3");
    wr16(3, 0, 'h0001, "R3 channel 3");
    update(3, 'h10);
    rd16(3, 1, "R5 wraparound");
    @(negedge clk); dir_down[3] = 1;
    rd16(3, 0, "R6 address below zero");
    // mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 4) access(1, 4'($urandom_range(0, 9)), 8'($urandom), "R2 random write");
      else if (r < 8) access(0, 4'($urandom_range(0, 9)), 8'h00, "R2 random read");
      else if (r == 8) update(int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)));
      else begin @(negedge clk); dir_down = 4'($urandom); end
    end
    repeat (3) @(negedge clk);
    check(q_exp[0].size() == 0 && q_exp[1].size() == 0, "R11 every read answered",
          q_exp[0].size() + q_exp[1].size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule